// File: doc/BRIEF.md
# CCD Exposure Shutter Controller

This block sets how long a CCD sensor integrates charge in each field. It does this by deciding on which lines of the field a substrate discharge pulse is fired. Every pulse empties the photosites. Exposure therefore only accumulates over the lines that follow the last pulse, up to the charge readout at the end of the field. With no pulses, the sensor integrates for the whole field.

The exposure setting comes from one of three sources, picked by mode pins in a fixed priority:
- an 8-bit up/down counter driven by digital iris requests, once per field;
- a 3-bit code read straight from three shared pins;
- an 8-bit word shifted in serially over those same pins, using a data line, a shift clock and a commit strobe.

The asynchronous pins are synchronized inside the block. Line and field strobes come from the sync generator in the block clock domain. A new setting is taken up only at a field strobe.

Top module: `exposure_shutter`

## Requirements
- R1: While `pulseEn` is low, no discharge pulse starts, any pulse in progress is dropped on the next cycle, a field run entirely with it low carries zero pulses (whole-field accumulation), and the iris counter does not step.
- R2: Each discharge pulse rises in the cycle after the line strobe that starts it, and stays high for exactly PULSE_CYCLES cycles (default 3).
- R3: A field strobe restarts the line count. With F field lines (262 when `stdSel`=0, 312 when `stdSel`=1) and E exposure lines, the first F−E lines after the field strobe carry one pulse each and the rest carry none. If E ≥ F, no line carries a pulse.
- R4: The source is the iris counter when `irisMode` is high, whatever `parallelSel` is. Otherwise it is the parallel code when `parallelSel` is high, and the serial word when `parallelSel` is low.
- R5: The parallel code `setPins[2:0]` gives E as follows:
  - 7: 157 lines (`stdSel`=0) or 130 lines (`stdSel`=1)
  - 6: 63 or 62 lines
  - 5: 31 lines
  - 4: 16 lines
  - 3: 8 lines
  - 2: 3 lines
  - 1: 2 lines
  - 0: 0 lines
- R6: In serial entry, `setPins[2]` is data, `setPins[1]` is the shift clock and `setPins[0]` is the commit strobe. Each shift clock rise moves the data bit into the LSB of the shift register, so the first of eight bits ends as bit 7. A strobe rise copies the shift register to the working word. E is the working word shifted right by one.
- R7: A change of source, code or word during a field does not alter that field's pulses. It applies from the next field strobe.
- R8: Shift clock and strobe edges on `setPins` are ignored while serial entry is not the selected source.
- R9: Shifting bits without a commit strobe leaves the working word unchanged.
- R10: The iris counter resets to 80h. At each field strobe in iris mode it rises by one when only `lengthenReq` is high and falls by one when only `shortenReq` is high, saturating at 00h and FFh, and holds otherwise. The field uses the count held before that strobe's step. E is the count shifted right by one.
- R11: After reset the output is low, line strobes before the first field strobe produce no pulse, and the serial working word is 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pulseEn | input | 1 | Discharge pulse enable |
| irisMode | input | 1 | High: iris counter sets exposure |
| parallelSel | input | 1 | High: parallel code, low: serial word (shutter mode) |
| stdSel | input | 1 | Line standard: 0 gives 262-line fields, 1 gives 312-line fields |
| setPins | input | 3 | Parallel code, or serial data/clock/strobe (asynchronous) |
| lengthenReq | input | 1 | Iris request for longer exposure (asynchronous) |
| shortenReq | input | 1 | Iris request for shorter exposure (asynchronous) |
| lineStrobe | input | 1 | One-cycle strobe at each line's blanking |
| fieldStrobe | input | 1 | One-cycle strobe at field start |
| dischargePulse | output | 1 | Substrate discharge pulse |

## Verification
Every parallel code is swept under both line standards. The position and width of each pulse are compared line by line, so an error in the table, the field length or the pulse timing each shows up as its own mismatch.

Serial words are tried in several ways:
- the fastest-setting word and words near both ends of the range, which tell bit order and the shift apart;
- shifts without a commit, which must change nothing;
- a bare commit, which must pick up the pending bits;
- clock and strobe activity during parallel mode, which must be ignored.

A code change in mid-field separates per-field latching from a live path. Long runs of short fields drive the iris counter into both saturation limits. Iris mode with the parallel select still high checks the source priority.

// File: rtl/exposure_shutter_pkg.sv
package exposure_shutter_pkg;

  typedef enum logic [1:0] {
    SRC_OFF      = 2'd0,
    SRC_IRIS     = 2'd1,
    SRC_PARALLEL = 2'd2,
    SRC_SERIAL   = 2'd3
  } setSrc_t;

  typedef struct packed {
    logic enable;
    logic fieldStart;
    logic lineStart;
    logic shiftIn;
    logic commit;
    logic stepLonger;
    logic stepShorter;
  } ctrlStrobe_t;

endpackage

// File: rtl/exposure_shutter_ctrl.sv
module exposure_shutter_ctrl
  import exposure_shutter_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pulseEn,
  input  logic        irisMode,
  input  logic        parallelSel,
  input  logic [2:0]  setPins,
  input  logic        lengthenReq,
  input  logic        shortenReq,
  input  logic        fieldStrobe,
  input  logic        lineStrobe,
  output ctrlStrobe_t strobes,
  output setSrc_t     src,
  output logic [2:0]  pinsSync
);

  localparam int ASYNC_W = 5;
  localparam int CHAIN_W = SYNC_STAGES * ASYNC_W;

  logic [CHAIN_W-1:0] chain;
  logic [ASYNC_W-1:0] rawIn;
  logic [ASYNC_W-1:0] syncOut;
  logic [1:0]         edgePrev;
  logic               clockRise;
  logic               strobeRise;
  logic               serialActive;

  assign rawIn   = {shortenReq, lengthenReq, setPins};
  assign syncOut = chain[CHAIN_W-1 -: ASYNC_W];

  // multi-flop synchronizer for every asynchronous input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain    <= '0;
      edgePrev <= '0;
    end else begin
      chain    <= {chain[CHAIN_W-ASYNC_W-1:0], rawIn};
      edgePrev <= syncOut[1:0];
    end
  end

  assign clockRise  = syncOut[1] & ~edgePrev[1];
  assign strobeRise = syncOut[0] & ~edgePrev[0];

  // fixed-priority source decode
  always_comb begin
    if (!pulseEn)         src = SRC_OFF;
    else if (irisMode)    src = SRC_IRIS;
    else if (parallelSel) src = SRC_PARALLEL;
    else                  src = SRC_SERIAL;
  end

  assign serialActive = (src == SRC_SERIAL);
  assign pinsSync     = syncOut[2:0];

  always_comb begin
    strobes             = '0;
    strobes.enable      = pulseEn;
    strobes.fieldStart  = fieldStrobe;
    strobes.lineStart   = lineStrobe;
    strobes.shiftIn     = serialActive & clockRise;
    strobes.commit      = serialActive & strobeRise;
    strobes.stepLonger  = fieldStrobe & (src == SRC_IRIS) & syncOut[3] & ~syncOut[4];
    strobes.stepShorter = fieldStrobe & (src == SRC_IRIS) & syncOut[4] & ~syncOut[3];
  end

endmodule

// File: rtl/exposure_shutter_dp.sv
module exposure_shutter_dp
  import exposure_shutter_pkg::*;
#(
  parameter int SET_W        = 8,
  parameter int LINES_STD0   = 262,
  parameter int LINES_STD1   = 312,
  parameter int PULSE_CYCLES = 3,
  parameter int LOAD_SHIFT   = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobes,
  input  setSrc_t     src,
  input  logic        stdSel,
  input  logic [2:0]  pinsSync,
  output logic        dischargePulse
);

  localparam int MAX_LINES = (LINES_STD1 > LINES_STD0) ? LINES_STD1 : LINES_STD0;
  localparam int LINE_W    = $clog2(MAX_LINES + 1);
  localparam int PW_W      = $clog2(PULSE_CYCLES + 1);
  localparam logic [SET_W-1:0] IRIS_INIT = SET_W'(1) << (SET_W - 1);
  localparam logic [SET_W-1:0] SET_MAX   = '1;

  logic [SET_W-1:0]  shiftReg;
  logic [SET_W-1:0]  workWord;
  logic [SET_W-1:0]  irisCount;
  logic [LINE_W-1:0] dischargeLines;
  logic [LINE_W-1:0] lineIdx;
  logic [PW_W-1:0]   pulseCnt;
  logic [LINE_W-1:0] fieldLines;
  logic [LINE_W-1:0] expLines;
  logic [LINE_W-1:0] nextDischarge;

  function automatic logic [LINE_W-1:0] codeLines(input logic [2:0] code, input logic std);
    case (code)
      3'd7:    return std ? LINE_W'(130) : LINE_W'(157);
      3'd6:    return std ? LINE_W'(62)  : LINE_W'(63);
      3'd5:    return LINE_W'(31);
      3'd4:    return LINE_W'(16);
      3'd3:    return LINE_W'(8);
      3'd2:    return LINE_W'(3);
      3'd1:    return LINE_W'(2);
      default: return '0;
    endcase
  endfunction

  assign fieldLines = stdSel ? LINE_W'(LINES_STD1) : LINE_W'(LINES_STD0);

  always_comb begin
    case (src)
      SRC_IRIS:     expLines = LINE_W'(irisCount >> LOAD_SHIFT);
      SRC_PARALLEL: expLines = codeLines(pinsSync, stdSel);
      SRC_SERIAL:   expLines = LINE_W'(workWord >> LOAD_SHIFT);
      default:      expLines = '0;
    endcase
    if (src == SRC_OFF || expLines >= fieldLines) nextDischarge = '0;
    else                                          nextDischarge = fieldLines - expLines;
  end

  // serial shift register and working word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      workWord <= '0;
    end else begin
      if (strobes.shiftIn) shiftReg <= {shiftReg[SET_W-2:0], pinsSync[2]};
      if (strobes.commit)  workWord <= shiftReg;
    end
  end

  // iris up/down counter, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irisCount <= IRIS_INIT;
    end else if (strobes.stepLonger && irisCount != SET_MAX) begin
      irisCount <= irisCount + 1'b1;
    end else if (strobes.stepShorter && irisCount != '0) begin
      irisCount <= irisCount - 1'b1;
    end
  end

  // per-field latch and line position
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dischargeLines <= '0;
      lineIdx        <= '0;
    end else if (strobes.fieldStart) begin
      dischargeLines <= nextDischarge;
      lineIdx        <= '0;
    end else if (strobes.lineStart && lineIdx != '1) begin
      lineIdx <= lineIdx + 1'b1;
    end
  end

  // pulse former
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
    end else if (!strobes.enable) begin
      pulseCnt <= '0;
    end else if (strobes.lineStart && !strobes.fieldStart && lineIdx < dischargeLines) begin
      pulseCnt <= PW_W'(PULSE_CYCLES);
    end else if (pulseCnt != '0) begin
      pulseCnt <= pulseCnt - 1'b1;
    end
  end

  assign dischargePulse = (pulseCnt != '0);

endmodule

// File: rtl/exposure_shutter.sv
module exposure_shutter
  import exposure_shutter_pkg::*;
#(
  parameter int SET_W        = 8,
  parameter int LINES_STD0   = 262,
  parameter int LINES_STD1   = 312,
  parameter int PULSE_CYCLES = 3,
  parameter int LOAD_SHIFT   = 1,
  parameter int SYNC_STAGES  = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pulseEn,
  input  logic       irisMode,
  input  logic       parallelSel,
  input  logic       stdSel,
  input  logic [2:0] setPins,
  input  logic       lengthenReq,
  input  logic       shortenReq,
  input  logic       lineStrobe,
  input  logic       fieldStrobe,
  output logic       dischargePulse
);

  ctrlStrobe_t strobes;
  setSrc_t     src;
  logic [2:0]  pinsSync;

  exposure_shutter_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .pulseEn     (pulseEn),
    .irisMode    (irisMode),
    .parallelSel (parallelSel),
    .setPins     (setPins),
    .lengthenReq (lengthenReq),
    .shortenReq  (shortenReq),
    .fieldStrobe (fieldStrobe),
    .lineStrobe  (lineStrobe),
    .strobes     (strobes),
    .src         (src),
    .pinsSync    (pinsSync)
  );

  exposure_shutter_dp #(
    .SET_W        (SET_W),
    .LINES_STD0   (LINES_STD0),
    .LINES_STD1   (LINES_STD1),
    .PULSE_CYCLES (PULSE_CYCLES),
    .LOAD_SHIFT   (LOAD_SHIFT)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .strobes        (strobes),
    .src            (src),
    .stdSel         (stdSel),
    .pinsSync       (pinsSync),
    .dischargePulse (dischargePulse)
  );

endmodule

// File: rtl/exposure_shutter_checks.sv
module exposure_shutter_checks #(
  parameter int PULSE_CYCLES = 3
) (
  input logic clk,
  input logic rstN,
  input logic pulseEn,
  input logic lineStrobe,
  input logic dischargePulse
);

  localparam int RUN_W = $clog2(PULSE_CYCLES + 2);

  logic [RUN_W-1:0] highRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                             highRun <= '0;
    else if (!dischargePulse)              highRun <= '0;
    else if (highRun != RUN_W'(PULSE_CYCLES + 1)) highRun <= highRun + 1'b1;
  end

  // R1: a low enable silences the output on the next cycle
  p_off_silent_r1: assert property (@(posedge clk) disable iff (!rstN)
    !pulseEn |=> !dischargePulse);

  // R1: a pulse only starts while enabled
  p_rise_enabled_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dischargePulse) |-> $past(pulseEn));

  // R2: a pulse only starts right after a line strobe
  p_rise_after_line_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dischargePulse) |-> $past(lineStrobe));

  // R2: a pulse never outlasts its programmed width
  p_width_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    dischargePulse |-> (highRun < RUN_W'(PULSE_CYCLES)));

endmodule

bind exposure_shutter exposure_shutter_checks #(
  .PULSE_CYCLES(PULSE_CYCLES)
) u_checks (
  .clk            (clk),
  .rstN           (rstN),
  .pulseEn        (pulseEn),
  .lineStrobe     (lineStrobe),
  .dischargePulse (dischargePulse)
);

// File: tb/exposure_shutter_bench.sv
module exposure_shutter_bench;

  localparam int L0 = 262;
  localparam int L1 = 312;
  localparam int PW = 3;
  localparam int LINE_CYC = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rstN = 1'b0;
  logic       pulseEn = 1'b0;
  logic       irisMode = 1'b0;
  logic       parallelSel = 1'b0;
  logic       stdSel = 1'b0;
  logic [2:0] setPins = 3'b000;
  logic       lengthenReq = 1'b0;
  logic       shortenReq = 1'b0;
  logic       lineStrobe = 1'b0;
  logic       fieldStrobe = 1'b0;
  logic       dischargePulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int irisModel = 128;

  exposure_shutter u_exposure_shutter (
    .clk            (clk),
    .rstN           (rstN),
    .pulseEn        (pulseEn),
    .irisMode       (irisMode),
    .parallelSel    (parallelSel),
    .stdSel         (stdSel),
    .setPins        (setPins),
    .lengthenReq    (lengthenReq),
    .shortenReq     (shortenReq),
    .lineStrobe     (lineStrobe),
    .fieldStrobe    (fieldStrobe),
    .dischargePulse (dischargePulse)
  );

  function automatic int codeTable(int code, int std);
    case (code)
      7: return std ? 130 : 157;
      6: return std ? 62 : 63;
      5: return 31;
      4: return 16;
      3: return 8;
      2: return 3;
      1: return 2;
      default: return 0;
    endcase
  endfunction

  function automatic int disLines(int fieldLen, int expLen);
    return (expLen >= fieldLen) ? 0 : fieldLen - expLen;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic runField(int nLines, int expDis, output int pulses, output int bad);
    bit expHigh;
    @(negedge clk) fieldStrobe = 1'b1;
    @(negedge clk) fieldStrobe = 1'b0;
    pulses = 0;
    bad = 0;
    for (int ln = 0; ln < nLines; ln++) begin
      lineStrobe = 1'b1;
      @(negedge clk);
      lineStrobe = 1'b0;
      for (int k = 0; k < LINE_CYC; k++) begin
        expHigh = (ln < expDis) && (k < PW);
        if (dischargePulse !== expHigh) bad++;
        if (k == 0 && dischargePulse === 1'b1) pulses++;
        if (k < LINE_CYC - 1) @(negedge clk);
      end
    end
  endtask

  task automatic fieldExpect(int nLines, int expDis, string req);
    int pulses;
    int bad;
    runField(nLines, expDis, pulses, bad);
    check(pulses == expDis, req, pulses, expDis);
    check(bad == 0, {req, " R2 pulse shape"}, bad, 0);
  endtask

  task automatic stepModel();
    if (pulseEn && irisMode) begin
      if (lengthenReq && !shortenReq && irisModel < 255) irisModel++;
      else if (shortenReq && !lengthenReq && irisModel > 0) irisModel--;
    end
  endtask

  task automatic irisField(string req);
    int latched;
    latched = irisModel;
    stepModel();
    fieldExpect(L0, disLines(L0, latched >> 1), req);
  endtask

  task automatic shortField();
    stepModel();
    @(negedge clk) fieldStrobe = 1'b1;
    @(negedge clk) fieldStrobe = 1'b0;
    idle(1);
  endtask

  task automatic sendWord(logic [7:0] w, bit commit);
    for (int i = 7; i >= 0; i--) begin
      setPins = {w[i], 1'b0, 1'b0};
      idle(4);
      setPins = {w[i], 1'b1, 1'b0};
      idle(4);
      setPins = {w[i], 1'b0, 1'b0};
      idle(4);
    end
    if (commit) begin
      setPins = 3'b001;
      idle(4);
    end
    setPins = 3'b000;
    idle(6);
  endtask

  initial begin : watchdog
    #(8 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog all requirements actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int highs;
    idle(5);
    check(dischargePulse === 1'b0, "R11 output low in reset", dischargePulse, 0);
    rstN = 1'b1;
    idle(3);
    check(dischargePulse === 1'b0, "R11 output low after reset", dischargePulse, 0);

    // R11: line strobes before any field strobe give no pulse
    pulseEn = 1'b1;
    parallelSel = 1'b1;
    setPins = 3'd7;
    idle(6);
    highs = 0;
    for (int n = 0; n < 10 * LINE_CYC; n++) begin
      lineStrobe = (n % LINE_CYC) == 0;
      @(negedge clk);
      if (dischargePulse === 1'b1) highs++;
    end
    lineStrobe = 1'b0;
    check(highs == 0, "R11 no pulse before first field", highs, 0);

    // R11: serial working word is 00h after reset
    parallelSel = 1'b0;
    setPins = 3'b000;
    idle(6);
    fieldExpect(L0, L0, "R11 reset word");

    // R1: enable low gives a pulse-free field
    pulseEn = 1'b0;
    idle(2);
    fieldExpect(L0, 0, "R1 disabled field");

    // R5 / R3: sweep every parallel code under both standards
    pulseEn = 1'b1;
    parallelSel = 1'b1;
    for (int std = 0; std < 2; std++) begin
      for (int code = 0; code < 8; code++) begin
        stdSel = std[0];
        setPins = code[2:0];
        idle(6);
        fieldExpect(std ? L1 : L0, disLines(std ? L1 : L0, codeTable(code, std)), "R5 R3 parallel");
      end
    end

    // R7: mid-field code change applies next field only
    stdSel = 1'b0;
    setPins = 3'd3;
    idle(6);
    fork
      fieldExpect(L0, L0 - 8, "R7 old code holds");
      begin
        idle(40);
        setPins = 3'd6;
      end
    join
    fieldExpect(L0, L0 - 63, "R7 new code next field");

    // R4: iris wins over parallel select
    irisMode = 1'b1;
    idle(4);
    irisField("R4 iris priority");
    irisMode = 1'b0;

    // R6: serial words
    parallelSel = 1'b0;
    setPins = 3'b000;
    idle(6);
    sendWord(8'h4E, 1'b1);
    fieldExpect(L0, disLines(L0, 8'h4E >> 1), "R6 word 4E");
    sendWord(8'hED, 1'b1);
    fieldExpect(L0, disLines(L0, 8'hED >> 1), "R6 word ED");
    stdSel = 1'b1;
    sendWord(8'hE1, 1'b1);
    fieldExpect(L1, disLines(L1, 8'hE1 >> 1), "R6 word E1 312-line");

    // R9: shift without commit changes nothing
    sendWord(8'h9C, 1'b0);
    fieldExpect(L1, disLines(L1, 8'hE1 >> 1), "R9 no commit");

    // R6: bare commit takes the pending bits
    setPins = 3'b001;
    idle(4);
    setPins = 3'b000;
    idle(6);
    fieldExpect(L1, disLines(L1, 8'h9C >> 1), "R6 late commit");
    stdSel = 1'b0;

    // R8: serial edges ignored in parallel mode
    parallelSel = 1'b1;
    idle(2);
    sendWord(8'h00, 1'b1);
    parallelSel = 1'b0;
    idle(6);
    fieldExpect(L0, disLines(L0, 8'h9C >> 1), "R8 ignored in parallel");

    // R6: fastest word
    sendWord(8'h00, 1'b1);
    fieldExpect(L0, L0, "R6 word 00");

    // R10: iris stepping and saturation
    irisMode = 1'b1;
    idle(4);
    irisField("R10 hold");
    lengthenReq = 1'b1;
    idle(6);
    irisField("R10 step up a");
    irisField("R10 step up b");
    irisField("R10 step up c");
    shortenReq = 1'b1;
    idle(6);
    irisField("R10 both hold a");
    irisField("R10 both hold b");
    lengthenReq = 1'b0;
    idle(6);
    for (int n = 0; n < 140; n++) shortField();
    irisField("R10 floor 00h");
    irisField("R10 floor stays");
    shortenReq = 1'b0;
    lengthenReq = 1'b1;
    idle(6);
    for (int n = 0; n < 300; n++) shortField();
    irisField("R10 ceiling FFh");
    irisField("R10 ceiling stays");

    // R1: disabled iris mode gives no pulse and no step
    pulseEn = 1'b0;
    idle(2);
    fieldExpect(L0, 0, "R1 disabled iris");
    stepModel();
    shortField();
    lengthenReq = 1'b0;
    shortenReq = 1'b1;
    idle(6);
    pulseEn = 1'b1;
    idle(2);
    irisField("R1 R10 no step while disabled");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule